// File: doc/BRIEF.md
# Rotor Lock Detector With Auto-Retry

This block supervises a single-phase fan drive. It watches the tachometer line, which changes level once per commutation, and treats any level change as proof that the rotor is turning. Elapsed time is measured in pulses of a slow timebase tick, which takes the place of a capacitor-timed oscillator. If a set number of ticks passes with no tachometer change, the block declares the rotor locked. While locked it turns off high-side drive and holds both low-side switches on, which brakes the winding.

A locked rotor is not held off forever. The block runs a repeating cycle. A long off window holds the brake. A short on window then restores normal drive so the motor can try to start again. The default window lengths are in a 15:1 ratio. A tachometer change seen during an on window ends the fault and returns the block to normal running. A lock flag stays high from the moment the lock is declared until that recovery.

States and transitions. The block has three states: RUN, LOCK_OFF and RETRY_ON.
- RUN goes to LOCK_OFF on timeout.
- RUN stays in RUN on a tachometer edge, which restarts the timeout.
- LOCK_OFF goes to RETRY_ON when the off window expires.
- RETRY_ON goes to RUN on a tachometer edge.
- RETRY_ON goes back to LOCK_OFF when the on window expires.
- A synchronous reset returns the block to RUN from any state.

Top module: `rotor_lock_guard`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in RUN with the tick counter cleared. RUN drives `hs_en`=1, `ls_hold`=0 and `lock_flag`=0, and a full timeout is needed before any lock after reset.
- R2: In RUN, the block moves to LOCK_OFF on the clock edge that samples the TIMEOUT_TICKS-th `osc_tick` pulse since the last restart, provided no tachometer edge arrives in between. One pulse fewer leaves it in RUN.
- R3: In LOCK_OFF the block drives `hs_en`=0 and `ls_hold`=1.
- R4: `lock_flag` is 1 in both LOCK_OFF and RETRY_ON, and 0 in RUN.
- R5: In RUN, a tachometer edge clears the tick count, so a further TIMEOUT_TICKS pulses are needed before a lock.
- R6: LOCK_OFF lasts exactly OFF_TICKS pulses. Tachometer edges during LOCK_OFF neither shorten nor restart this window.
- R7: When the off window expires, the block enters RETRY_ON and drives `hs_en`=1, `ls_hold`=0 and `lock_flag`=1.
- R8: If no tachometer edge arrives within ON_TICKS pulses in RETRY_ON, the block returns to LOCK_OFF.
- R9: A tachometer edge during RETRY_ON returns the block to RUN, with `lock_flag` low and the count cleared.
- R10: In RUN, if a tachometer edge and the pulse that would end the timeout reach the state machine in the same cycle, the edge wins: the block stays in RUN and the count restarts.
- R11: `fg_in` passes through a two-stage synchronizer. A level change in either direction acts on the state machine at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle timebase pulse |
| fg_in | input | 1 | Tachometer level, asynchronous |
| hs_en | output | 1 | High-side drive permitted |
| ls_hold | output | 1 | Both low-side switches held on (brake) |
| lock_flag | output | 1 | Locked-rotor fault indicator |

## Verification
The assertions assume three things about the inputs:
- `osc_tick` is a single-cycle pulse.
- `fg_in` holds each level longer than the synchronizer depth, so every change yields exactly one edge.
- Reset is held for at least one clock.

The stimulus respects all three. It spaces tick pulses two clocks apart and waits three clocks after each tachometer toggle. After a mid-run reset, it waits several clocks before sending the first tick, so the synchronizer settles first.

// File: rtl/rld_pkg.sv
package rld_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_LOCK_OFF = 2'd1,
        ST_RETRY_ON = 2'd2
    } rld_state_e;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fg_edge_sync.sv
module fg_edge_sync #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fg_in,
    output logic edge_o
);
    localparam int unsigned LAST = SYNC_STAGES;

    logic [LAST:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q[0] <= fg_in;
        end
    end

    generate
        for (genvar g = 1; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) sh_q[g] <= 1'b0;
                else     sh_q[g] <= sh_q[g-1];
            end
        end
    endgenerate

    assign edge_o = sh_q[LAST] ^ sh_q[LAST-1];

endmodule

// File: rtl/tick_window_cnt.sv
module tick_window_cnt #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (tick_i)  cnt_q <= cnt_q + CW'(1);
    end

    assign expire_o = tick_i && (cnt_q == (limit_i - CW'(1)));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit_i);

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import rld_pkg::*;
#(
    parameter int unsigned CW            = 7,
    parameter int unsigned TIMEOUT_TICKS = 8,
    parameter int unsigned ON_TICKS      = 8,
    parameter int unsigned OFF_TICKS     = 120
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          edge_i,
    input  logic          expire_i,
    output logic          clr_o,
    output logic [CW-1:0] limit_o,
    output logic          hs_en_o,
    output logic          ls_hold_o,
    output logic          lock_o
);
    rld_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (!edge_i && expire_i) state_d = ST_LOCK_OFF;
            end
            ST_LOCK_OFF: begin
                if (expire_i) state_d = ST_RETRY_ON;
            end
            ST_RETRY_ON: begin
                if (edge_i)        state_d = ST_RUN;
                else if (expire_i) state_d = ST_LOCK_OFF;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        clr_o = (state_d != state_q) || (edge_i && (state_q != ST_LOCK_OFF));
        unique case (state_q)
            ST_LOCK_OFF: limit_o = CW'(OFF_TICKS);
            ST_RETRY_ON: limit_o = CW'(ON_TICKS);
            default:     limit_o = CW'(TIMEOUT_TICKS);
        endcase
    end

    always_comb begin
        hs_en_o   = 1'b1;
        ls_hold_o = 1'b0;
        lock_o    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                hs_en_o = 1'b1;
            end
            ST_LOCK_OFF: begin
                hs_en_o   = 1'b0;
                ls_hold_o = 1'b1;
                lock_o    = 1'b1;
            end
            ST_RETRY_ON: begin
                lock_o = 1'b1;
            end
            default: begin
                hs_en_o = 1'b1;
            end
        endcase
    end

    // R2
    lock_entry_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK_OFF && $past(state_q) == ST_RUN) |-> $past(tick_i));

    // R3
    brake_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ls_hold_o |-> !hs_en_o);

    // R4
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> ls_hold_o);

    // R9
    lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_o) |-> $past(edge_i));

    // R6
    off_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK_OFF && !tick_i) |=> state_q == ST_LOCK_OFF);

endmodule

// File: rtl/rotor_lock_guard.sv
module rotor_lock_guard
    import rld_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 8,
    parameter int unsigned ON_TICKS      = 8,
    parameter int unsigned OFF_TICKS     = 120,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic fg_in,
    output logic hs_en,
    output logic ls_hold,
    output logic lock_flag
);
    localparam int unsigned MAX_TICKS = max3(TIMEOUT_TICKS, ON_TICKS, OFF_TICKS);
    localparam int unsigned CW        = $clog2(MAX_TICKS + 1);

    logic          fg_edge;
    logic          win_clr;
    logic          win_expire;
    logic [CW-1:0] win_limit;

    fg_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .fg_in  (fg_in),
        .edge_o (fg_edge)
    );

    tick_window_cnt #(
        .CW (CW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (win_clr),
        .tick_i   (osc_tick),
        .limit_i  (win_limit),
        .expire_o (win_expire)
    );

    lock_fsm #(
        .CW            (CW),
        .TIMEOUT_TICKS (TIMEOUT_TICKS),
        .ON_TICKS      (ON_TICKS),
        .OFF_TICKS     (OFF_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (osc_tick),
        .edge_i    (fg_edge),
        .expire_i  (win_expire),
        .clr_o     (win_clr),
        .limit_o   (win_limit),
        .hs_en_o   (hs_en),
        .ls_hold_o (ls_hold),
        .lock_o    (lock_flag)
    );

endmodule

// File: tb/rotor_lock_guard_tb.sv
module rotor_lock_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 8;
    localparam int ONW = 8;
    localparam int OFFW = 120;
    localparam logic [2:0] EXP_RUN   = 3'b010;
    localparam logic [2:0] EXP_OFF   = 3'b101;
    localparam logic [2:0] EXP_RETRY = 3'b110;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic fg_in = 1'b0;
    logic hs_en, ls_hold, lock_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rotor_lock_guard #(
        .TIMEOUT_TICKS (TMO),
        .ON_TICKS      (ONW),
        .OFF_TICKS     (OFFW),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .fg_in     (fg_in),
        .hs_en     (hs_en),
        .ls_hold   (ls_hold),
        .lock_flag (lock_flag)
    );

    task automatic expect_out(input logic [2:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
        end
    endtask

    task automatic toggle_fg();
        @(negedge clk) fg_in = ~fg_in;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops expectations and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [2:0] e;
                logic [2:0] a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {lock_flag, hs_en, ls_hold};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual {lock,hs,ls}=%b expected %b", t, a, e);
                end
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_out(EXP_RUN, "R1 reset state");

        ticks(TMO - 1);
        expect_out(EXP_RUN, "R2 one tick short of timeout");
        ticks(1);
        expect_out(EXP_OFF, "R2 R3 R4 lock on timeout");

        // R1: reset from LOCK_OFF, full timeout needed again
        do_reset();
        expect_out(EXP_RUN, "R1 reset from lock");

        // R5 restart by FG edge (rising)
        ticks(5);
        toggle_fg();
        ticks(TMO - 1);
        expect_out(EXP_RUN, "R5 R11 edge restarted timeout");
        ticks(1);
        expect_out(EXP_OFF, "R5 lock after full timeout from edge");

        // R6: off window with FG edge in the middle (ignored)
        ticks(50);
        toggle_fg();
        ticks(OFFW - 50 - 1);
        expect_out(EXP_OFF, "R6 off window not ended by edge");
        ticks(1);
        expect_out(EXP_RETRY, "R7 R4 retry after off window");

        // R8: on window expires
        ticks(ONW - 1);
        expect_out(EXP_RETRY, "R8 still in retry");
        ticks(1);
        expect_out(EXP_OFF, "R8 back to off window");

        // again to retry, then recover via FG edge (falling)
        ticks(OFFW);
        expect_out(EXP_RETRY, "R7 second retry");
        toggle_fg();
        expect_out(EXP_RUN, "R9 R11 recovery on edge");

        // R9: count cleared on recovery
        ticks(TMO - 1);
        expect_out(EXP_RUN, "R9 count cleared at recovery");

        // R10: edge and final tick together (count now TMO-1)
        @(negedge clk) fg_in = ~fg_in;
        @(negedge clk);
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        expect_out(EXP_RUN, "R10 edge beats final tick");
        ticks(TMO - 1);
        expect_out(EXP_RUN, "R10 count restarted");
        ticks(1);
        expect_out(EXP_OFF, "R10 lock after restarted timeout");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule